// File: doc/BRIEF.md
# Two-stream word-interleaving serializer

This block merges two continuous one-bit data streams, A and B, into one serial output that runs at twice their rate. Both inputs share one bit clock. The block runs entirely in the fast output clock domain, and an input strobe marks the fast-clock cycles on which a new pair of input bits is present. Each stream is collected into 32-bit words. The output line then carries a 32-bit word of A followed directly by a 32-bit word of B, and repeats without gaps. A select line tells the receiver which stream is on the wire, in the manner of a left/right word clock on a stereo audio link.

Capture uses two buffer banks per stream in ping-pong fashion. While one bank pair is being shifted out, the next 32 bits of each stream fill the other bank pair. The banks change roles on the strobe that completes a word, and that same strobe restarts the output frame. This keeps the input alignment to the frame fixed. The input side has no back-pressure: a raw bitstream cannot be stalled. Every strobed bit must therefore be taken, and the strobe must arrive exactly every second fast-clock cycle once output has started.

Top module: `ilv_serializer`

## Requirements
- R1: While `rst` is high and in the cycle after it, `ser_dout`, `ser_sel` and `ser_live` are all 0.
- R2: Once output has started, every 64-cycle frame carries 32 bits of stream A followed by 32 bits of stream B, with frames back to back and no idle bit.
- R3: Within a word, the bit that was strobed in first is sent first (it is the word's most significant bit).
- R4: `ser_sel` is 0 for the A word and 1 for the B word, and it leads each word boundary by one bit. At frame positions 0..63 it is high exactly at positions 31 through 62.
- R5: `ser_live` rises on the edge that takes the 32nd strobed bit after reset and stays high. Before that, `ser_dout` and `ser_sel` stay 0. Frame position 0 is the cycle right after that edge.
- R6: A word pair is sent in the frame that immediately follows its capture. Bits captured during a frame do not disturb the word pair being sent.
- R7: `in_a` and `in_b` are ignored in cycles where `in_vld` is 0.
- R8: A reset while output is running drops `ser_live`, and output starts again only after 32 new strobed bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, one cycle per output bit |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Strobe: `in_a`/`in_b` hold a new bit this cycle (every second cycle) |
| in_a | input | 1 | Stream A input bit |
| in_b | input | 1 | Stream B input bit |
| ser_dout | output | 1 | Interleaved serial data, MSB first |
| ser_sel | output | 1 | Stream select: 0 = A word, 1 = B word, one bit early |
| ser_live | output | 1 | High once the first complete frame is on the wire |

## Verification
The assertions check the following on every cycle:
- A word completes only on the last position of a running frame.
- Each strobe lands in the least significant bit of the bank being written.
- The bank being read holds still until the banks swap.
- `ser_live` never falls outside reset.
- `ser_sel` changes only on the two frame positions where it may.

Only the bench scenarios can show that the bits on the wire are the right ones, in the right order and in the right frame, across different patterns. Only the bench can show that off-strobe input changes are dropped and that a mid-stream reset restarts the 32-bit fill.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int DEF_WORD_W = 32;

  typedef enum logic {
    STREAM_A = 1'b0,
    STREAM_B = 1'b1
  } stream_e;
endpackage

// File: rtl/ilv_capture.sv
module ilv_capture #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  input  logic              wr_bank,
  output logic [WORD_W-1:0] rd_word
);
  localparam int NBANK = 2;

  logic [WORD_W-1:0] w0, w1;

  for (genvar g = 0; g < NBANK; g++) begin : gen_bank
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= '0;
      end else if (shift_en && (wr_bank == 1'(g))) begin
        word_q <= {word_q[WORD_W-2:0], bit_in};
      end
    end

    assert_shift_lsb_R3: assert property (@(posedge clk) disable iff (rst)
      (shift_en && (wr_bank == 1'(g))) |=> (word_q[0] == $past(bit_in)));
  end

  assign w0 = gen_bank[0].word_q;
  assign w1 = gen_bank[1].word_q;

  // read side is always the bank not being written
  always_comb begin
    rd_word = wr_bank ? w0 : w1;
  end

  assert_read_bank_hold_R6: assert property (@(posedge clk) disable iff (rst)
    $stable(wr_bank) |-> $stable(rd_word));
endmodule

// File: rtl/ilv_frame_ctl.sv
module ilv_frame_ctl #(
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(WORD_W),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  output logic             wr_bank,
  output logic [CNT_W-1:0] out_cnt,
  output logic             live
);
  localparam int FRAME = 2 * WORD_W;

  logic [IDX_W-1:0] cap_cnt;
  logic             swap;

  assign swap = in_vld && (cap_cnt == IDX_W'(WORD_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_cnt <= '0;
      wr_bank <= 1'b0;
      out_cnt <= '0;
      live    <= 1'b0;
    end else begin
      if (in_vld) begin
        cap_cnt <= cap_cnt + 1'b1;
      end
      if (swap) begin
        wr_bank <= ~wr_bank;
        out_cnt <= '0;
        live    <= 1'b1;
      end else if (live) begin
        out_cnt <= out_cnt + 1'b1;
      end
    end
  end

  assert_swap_at_frame_end_R2: assert property (@(posedge clk) disable iff (rst)
    (swap && live) |-> (out_cnt == CNT_W'(FRAME - 1)));

  assert_swap_flips_bank_R6: assert property (@(posedge clk) disable iff (rst)
    swap |=> (wr_bank != $past(wr_bank)));

  assert_live_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    live |=> live);
endmodule

// File: rtl/ilv_out_mux.sv
module ilv_out_mux
  import ilv_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(WORD_W),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              live,
  input  logic [CNT_W-1:0]  out_cnt,
  input  logic [WORD_W-1:0] word_a,
  input  logic [WORD_W-1:0] word_b,
  output logic              dout,
  output logic              sel
);
  stream_e          cur;
  logic [IDX_W-1:0] pick;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    cur  = stream_e'(out_cnt[CNT_W-1]);
    pick = IDX_W'(WORD_W - 1) - out_cnt[IDX_W-1:0];
    nxt  = out_cnt + 1'b1;
    if (!live) begin
      dout = 1'b0;
    end else if (cur == STREAM_A) begin
      dout = word_a[pick];
    end else begin
      dout = word_b[pick];
    end
    // select shows the stream of the following bit
    sel = live && (stream_e'(nxt[CNT_W-1]) == STREAM_B);
  end
endmodule

// File: rtl/ilv_serializer.sv
module ilv_serializer
  import ilv_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W
) (
  input  logic clk,
  input  logic rst,
  input  logic in_vld,
  input  logic in_a,
  input  logic in_b,
  output logic ser_dout,
  output logic ser_sel,
  output logic ser_live
);
  localparam int IDX_W = $clog2(WORD_W);
  localparam int CNT_W = IDX_W + 1;

  logic              wr_bank;
  logic [CNT_W-1:0]  out_cnt;
  logic              live;
  logic [WORD_W-1:0] word_a, word_b;

  ilv_frame_ctl #(.WORD_W(WORD_W)) u_ctl (
    .clk(clk), .rst(rst), .in_vld(in_vld),
    .wr_bank(wr_bank), .out_cnt(out_cnt), .live(live)
  );

  ilv_capture #(.WORD_W(WORD_W)) u_cap_a (
    .clk(clk), .rst(rst), .shift_en(in_vld), .bit_in(in_a),
    .wr_bank(wr_bank), .rd_word(word_a)
  );

  ilv_capture #(.WORD_W(WORD_W)) u_cap_b (
    .clk(clk), .rst(rst), .shift_en(in_vld), .bit_in(in_b),
    .wr_bank(wr_bank), .rd_word(word_b)
  );

  ilv_out_mux #(.WORD_W(WORD_W)) u_mux (
    .live(live), .out_cnt(out_cnt), .word_a(word_a), .word_b(word_b),
    .dout(ser_dout), .sel(ser_sel)
  );

  assign ser_live = live;

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !ser_live |-> (!ser_dout && !ser_sel));

  assert_sel_edges_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(live) && ($past(out_cnt) != CNT_W'(WORD_W - 2)) &&
     ($past(out_cnt) != CNT_W'(2 * WORD_W - 2))) |-> $stable(ser_sel));
endmodule

// File: tb/ilv_serializer_tb_top.sv
module ilv_serializer_tb_top;
  localparam int W = 32;
  localparam int F = 2 * W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, in_vld = 1'b0, in_a = 1'b0, in_b = 1'b0;
  logic ser_dout, ser_sel, ser_live;

  int n_chk = 0, n_bad = 0;

  logic [W-1:0] m_acc_a = '0, m_acc_b = '0, m_fa = '0, m_fb = '0;
  int  m_cnt = 0, m_pos = 0;
  bit  m_live = 0;
  logic [15:0] lfsr = 16'hACE1;

  ilv_serializer #(.WORD_W(W)) dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_a(in_a), .in_b(in_b),
    .ser_dout(ser_dout), .ser_sel(ser_sel), .ser_live(ser_live)
  );

  task automatic chk(input bit ok, input string req, input logic act, input logic exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // one fast-clock cycle: drive, clock, update model, compare
  task automatic tick(input logic v, input logic a, input logic b);
    logic exp_d, exp_s;
    in_vld = v; in_a = a; in_b = b;
    @(posedge clk);
    if (v) begin
      m_acc_a = {m_acc_a[W-2:0], a};
      m_acc_b = {m_acc_b[W-2:0], b};
      m_cnt++;
    end
    if (v && m_cnt == W) begin
      m_cnt = 0; m_fa = m_acc_a; m_fb = m_acc_b; m_live = 1; m_pos = 0;
    end else if (m_live) begin
      m_pos = (m_pos + 1) % F;
    end
    @(negedge clk);
    exp_d = m_live ? ((m_pos < W) ? m_fa[W-1-m_pos] : m_fb[F-1-m_pos]) : 1'b0;
    exp_s = m_live && (m_pos >= W - 1) && (m_pos <= F - 2);
    chk(ser_dout === exp_d, "R2 R3 R6 R7 data", ser_dout, exp_d);
    chk(ser_sel === exp_s, "R4 select", ser_sel, exp_s);
    chk(ser_live === logic'(m_live), "R5 live", ser_live, logic'(m_live));
  endtask

  task automatic do_reset();
    rst = 1'b1; in_vld = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(ser_dout === 1'b0, "R1 R8 dout in reset", ser_dout, 1'b0);
    chk(ser_sel === 1'b0, "R1 R8 sel in reset", ser_sel, 1'b0);
    chk(ser_live === 1'b0, "R1 R8 live in reset", ser_live, 1'b0);
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    m_acc_a = '0; m_acc_b = '0; m_fa = '0; m_fb = '0;
    m_cnt = 0; m_pos = 0; m_live = 0;
  endtask

  // mode 0: pseudo-random, 1: A ones / B zeros, 2: alternating
  task automatic stream(input int strobes, input int mode);
    for (int i = 0; i < strobes; i++) begin
      logic a, b;
      case (mode)
        1:       begin a = 1'b1; b = 1'b0; end
        2:       begin a = i[0]; b = ~i[0]; end
        default: begin a = step_lfsr(); b = step_lfsr(); end
      endcase
      tick(1'b1, a, b);
      tick(1'b0, ~a, ~b);  // R7: off-strobe garbage must be ignored
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    tick(1'b0, 1'b1, 1'b1);
    chk(ser_live === 1'b0, "R1 live after reset", ser_live, 1'b0);
  endtask

  task automatic t_first_frame();
    stream(W - 1, 0);
    chk(ser_live === 1'b0, "R5 not live before 32nd strobe", ser_live, 1'b0);
    stream(1, 0);
    chk(ser_live === 1'b1, "R5 live after 32nd strobe", ser_live, 1'b1);
    stream(2 * W, 0);
  endtask

  task automatic t_prbs();
    stream(40 * W, 0);
  endtask

  task automatic t_fixed_patterns();
    stream(3 * W, 1);
    stream(3 * W, 2);
  endtask

  task automatic t_ignore_offstrobe();
    for (int i = 0; i < 4 * W; i++) begin
      logic a;
      a = step_lfsr();
      tick(1'b1, a, ~a);
      tick(1'b0, step_lfsr(), step_lfsr());
    end
  endtask

  task automatic t_midreset();
    stream(20, 0);
    do_reset();
    stream(W - 1, 0);
    chk(ser_live === 1'b0, "R8 still idle after 31 strobes", ser_live, 1'b0);
    chk(ser_sel === 1'b0, "R8 sel idle after reset", ser_sel, 1'b0);
    stream(1, 0);
    chk(ser_live === 1'b1, "R8 live again after 32 strobes", ser_live, 1'b1);
    stream(3 * W, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset_state();
    t_first_frame();
    t_prbs();
    t_fixed_patterns();
    t_ignore_offstrobe();
    t_midreset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule